// File: doc/BRIEF.md
# FIFO Slice Depth-Expansion Controller

This block is the control logic placed beside each slice of a FIFO that can be chained with identical slices into one deeper queue. It holds two ownership tokens, one for writing and one for reading. Only the slice holding the write token stores the incoming word, and only the slice holding the read token supplies and drives the outgoing word. Each slice keeps its own local write and read addresses. When a slice accepts the last word its storage can hold, or gives up its last stored word, it fires a pulse to the next slice in the ring, and that slice takes over the matching token. The output of the last slice wraps back to the input of the first, so the chain behaves as one ring buffer. The storage array and the per-slice occupancy counting sit outside this block; their full, empty and half-full flags arrive as inputs.

A mode input selects between a chained slice and a slice used on its own. In standalone mode both tokens count as always held. The write-handoff output then carries the slice's half-full flag, and the first-load input becomes a retransmit request that returns the read address to zero. In chained mode the first-load level sampled during reset decides which slice starts with both tokens. Chain-level full and empty flags are formed along a daisy chain of active-low signals. A slice pulls the chain low only for the flag tied to a token it holds.

Top module: `fifo_xchain_ctl`

## Requirements
- R1: During synchronous reset (rst_n low at a clock edge) both tokens take the value of first_load_i and both local addresses become 0.
- R2: wr_en_o is high exactly when wr_req_i is high, the slice owns writing (standalone, or chained with the write token) and full_i is low.
- R3: rd_en_o is high exactly when rd_req_i is high, the slice owns reading, empty_i is low and no retransmit is requested in that cycle.
- R4: In chained mode, an accepted write at local address DEPTH-1 raises xout_wr_o in the same cycle. After that edge the slice no longer holds the write token (unless xin_wr_i was also high) and its write address is 0.
- R5: In chained mode, an accepted read at local address DEPTH-1 raises xout_rd_o in the same cycle. After that edge the read token is gone (unless xin_rd_i was also high) and the read address is 0.
- R6: In chained mode, xin_wr_i (xin_rd_i) high at a clock edge gives the slice the write (read) token from the next cycle on. In a ring of S slices of depth D, global write number k (counting from 0) lands in slice (k/D) mod S at address k mod D, and reads follow the same mapping.
- R7: oe_o is high only when the slice owns reading and empty_i is low, so at most one slice in a chain drives data.
- R8: In standalone mode (cascade_i low), xout_wr_o equals half_i and xout_rd_o is 0. xin_wr_i and xin_rd_i have no effect on the enables.
- R9: In standalone mode, first_load_i high blocks the read in that cycle and sets the read address to 0 at the next edge. Writes are unaffected.
- R10: full_n_o = full_n_i AND NOT(owns writing AND full_i), and empty_n_o = empty_n_i AND NOT(owns reading AND empty_i). In a ring whose first slice sees 1 on both inputs, the last slice's outputs are low exactly when the whole chain is full or empty.
- R11: Each accepted write (read) advances the local write (read) address by one, wrapping from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cascade_i | input | 1 | 1 = chained slice, 0 = standalone |
| first_load_i | input | 1 | Chained: owns tokens after reset; standalone: retransmit |
| wr_req_i | input | 1 | Shared write request |
| rd_req_i | input | 1 | Shared read request |
| full_i | input | 1 | Local slice full |
| empty_i | input | 1 | Local slice empty |
| half_i | input | 1 | Local slice above half full |
| xin_wr_i | input | 1 | Write handoff from previous slice |
| xin_rd_i | input | 1 | Read handoff from previous slice |
| full_n_i | input | 1 | Chain full, active low, from previous slice |
| empty_n_i | input | 1 | Chain empty, active low, from previous slice |
| wr_en_o | output | 1 | Local store enable |
| rd_en_o | output | 1 | Local read advance enable |
| wr_addr_o | output | AW | Local write address |
| rd_addr_o | output | AW | Local read address |
| oe_o | output | 1 | Data output drive enable |
| xout_wr_o | output | 1 | Write handoff pulse; half-full in standalone |
| xout_rd_o | output | 1 | Read handoff pulse |
| full_n_o | output | 1 | Chain full, active low, to next slice |
| empty_n_o | output | 1 | Chain empty, active low, to next slice |

## Verification
The embedded properties check on every cycle the token state after reset, the loss of a token at a wrap, the gain of a token on an incoming pulse, the one-step address advance and the retransmit address clear. Only the bench scenarios can show that a three-slice ring puts every global write and read in the right slice and address and returns the data in order, including across several ring wraps. They also show that the daisy-chained flags report chain full and chain empty exactly, and that standalone mode ignores handoff pulses and routes half-full.

// File: rtl/fifo_xchain_ctl.sv
module fifo_xchain_ctl #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cascade_i,
  input  logic          first_load_i,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          full_i,
  input  logic          empty_i,
  input  logic          half_i,
  input  logic          xin_wr_i,
  input  logic          xin_rd_i,
  input  logic          full_n_i,
  input  logic          empty_n_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          oe_o,
  output logic          xout_wr_o,
  output logic          xout_rd_o,
  output logic          full_n_o,
  output logic          empty_n_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          wr_tok, rd_tok;
  logic [AW-1:0] wr_ptr, rd_ptr;

  wire retx   = ~cascade_i & first_load_i;
  wire wr_own = ~cascade_i | wr_tok;
  wire rd_own = ~cascade_i | rd_tok;

  assign wr_en_o = wr_req_i & wr_own & ~full_i;
  assign rd_en_o = rd_req_i & rd_own & ~empty_i & ~retx;

  wire wr_wrap = wr_en_o & (wr_ptr == LAST);
  wire rd_wrap = rd_en_o & (rd_ptr == LAST);

  assign xout_wr_o = cascade_i ? wr_wrap : half_i;
  assign xout_rd_o = cascade_i & rd_wrap;
  assign oe_o      = rd_own & ~empty_i;
  assign full_n_o  = full_n_i & ~(wr_own & full_i);
  assign empty_n_o = empty_n_i & ~(rd_own & empty_i);
  assign wr_addr_o = wr_ptr;
  assign rd_addr_o = rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_tok <= first_load_i;
      rd_tok <= first_load_i;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (cascade_i) begin
        wr_tok <= (wr_tok & ~wr_wrap) | xin_wr_i;
        rd_tok <= (rd_tok & ~rd_wrap) | xin_rd_i;
      end
      if (wr_en_o) wr_ptr <= wr_wrap ? '0 : wr_ptr + 1'b1;
      if (retx)         rd_ptr <= '0;
      else if (rd_en_o) rd_ptr <= rd_wrap ? '0 : rd_ptr + 1'b1;
    end
  end

  a_r1_reset_tokens: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wr_tok == $past(first_load_i)) && (rd_tok == $past(first_load_i))
                     && (wr_ptr == '0) && (rd_ptr == '0));

  a_r4_wr_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_i && wr_en_o && wr_ptr == LAST && !xin_wr_i) |=> (!wr_tok && wr_ptr == '0));

  a_r5_rd_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_i && rd_en_o && rd_ptr == LAST && !xin_rd_i) |=> (!rd_tok && rd_ptr == '0));

  a_r6_take_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_i && xin_wr_i) |=> wr_tok);

  a_r6_take_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_i && xin_rd_i) |=> rd_tok);

  a_r9_retx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade_i && first_load_i) |=> (rd_ptr == '0));

  a_r11_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_ptr != LAST) |=> (wr_ptr - $past(wr_ptr) == AW'(1)));

  a_r11_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && !retx && rd_ptr != LAST) |=> (rd_ptr - $past(rd_ptr) == AW'(1)));
endmodule

// File: tb/fifo_xchain_ctl_tb.sv
module fifo_xchain_ctl_tb;
  localparam int S = 3;
  localparam int D = 4;
  localparam int N = S * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [8:0] wdata = '0;
  logic [S-1:0] wr_en, rd_en, xw, xr, oe, fno, eno, full, empty;
  logic [1:0] wa [S];
  logic [1:0] ra [S];
  int cnt [S];
  logic [8:0] mem [N];

  for (genvar i = 0; i < S; i++) begin : g_ring
    fifo_xchain_ctl #(.DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .cascade_i(1'b1), .first_load_i(i == 0),
      .wr_req_i(wr_req), .rd_req_i(rd_req), .full_i(full[i]), .empty_i(empty[i]),
      .half_i(1'b0), .xin_wr_i(xw[(i+S-1)%S]), .xin_rd_i(xr[(i+S-1)%S]),
      .full_n_i(i == 0 ? 1'b1 : fno[(i+S-1)%S]), .empty_n_i(i == 0 ? 1'b1 : eno[(i+S-1)%S]),
      .wr_en_o(wr_en[i]), .rd_en_o(rd_en[i]), .wr_addr_o(wa[i]), .rd_addr_o(ra[i]),
      .oe_o(oe[i]), .xout_wr_o(xw[i]), .xout_rd_o(xr[i]),
      .full_n_o(fno[i]), .empty_n_o(eno[i]));
  end

  always_comb
    for (int i = 0; i < S; i++) begin
      full[i]  = (cnt[i] == D);
      empty[i] = (cnt[i] == 0);
    end

  always @(posedge clk)
    for (int i = 0; i < S; i++) begin
      if (!rst_n) cnt[i] <= 0;
      else begin
        if (wr_en[i]) mem[i*D + int'(wa[i])] <= wdata;
        cnt[i] <= cnt[i] + int'(wr_en[i]) - int'(rd_en[i]);
      end
    end

  logic sa_wr = 1'b0, sa_rd = 1'b0, sa_full = 1'b0, sa_empty = 1'b0;
  logic sa_half = 1'b0, sa_fl = 1'b0, sa_xw = 1'b0, sa_xr = 1'b0;
  logic sa_wen, sa_ren, sa_oe, sa_xow, sa_xor, sa_fno, sa_eno;
  logic [1:0] sa_wa, sa_ra;

  if (1) begin : g_sa
    fifo_xchain_ctl #(.DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .cascade_i(1'b0), .first_load_i(sa_fl),
      .wr_req_i(sa_wr), .rd_req_i(sa_rd), .full_i(sa_full), .empty_i(sa_empty),
      .half_i(sa_half), .xin_wr_i(sa_xw), .xin_rd_i(sa_xr),
      .full_n_i(1'b1), .empty_n_i(1'b1),
      .wr_en_o(sa_wen), .rd_en_o(sa_ren), .wr_addr_o(sa_wa), .rd_addr_o(sa_ra),
      .oe_o(sa_oe), .xout_wr_o(sa_xow), .xout_rd_o(sa_xor),
      .full_n_o(sa_fno), .empty_n_o(sa_eno));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] fval(input int k);
    return 9'((k * 37 + 5) & 511);
  endfunction

  int wcount = 0, rcount = 0;

  task automatic step(input bit w, input bit r);
    int tot, ws, rs, ew, er, exw, exr;
    bit wok, rok;
    @(negedge clk);
    wr_req = w; rd_req = r; wdata = fval(wcount);
    #1;
    tot = wcount - rcount;
    wok = w && tot < N;
    rok = r && tot > 0;
    ws = (wcount / D) % S;
    rs = (rcount / D) % S;
    ew  = wok ? (1 << ws) : 0;
    er  = rok ? (1 << rs) : 0;
    exw = (wok && wcount % D == D-1) ? (1 << ws) : 0;
    exr = (rok && rcount % D == D-1) ? (1 << rs) : 0;
    chk(int'(wr_en) == ew, "R2/R6 write owner", int'(wr_en), ew);
    chk(int'(rd_en) == er, "R3/R6 read owner", int'(rd_en), er);
    chk(int'(xw) == exw, "R4 write handoff", int'(xw), exw);
    chk(int'(xr) == exr, "R5 read handoff", int'(xr), exr);
    chk(int'(oe) == (tot > 0 ? (1 << rs) : 0), "R7 output drive", int'(oe), tot > 0 ? (1 << rs) : 0);
    chk(fno[S-1] == (tot != N), "R10 chain full", int'(fno[S-1]), int'(tot != N));
    chk(eno[S-1] == (tot != 0), "R10 chain empty", int'(eno[S-1]), int'(tot != 0));
    if (wok) chk(int'(wa[ws]) == wcount % D, "R11 write address", int'(wa[ws]), wcount % D);
    if (rok) begin
      chk(int'(ra[rs]) == rcount % D, "R11 read address", int'(ra[rs]), rcount % D);
      chk(mem[rs*D + rcount % D] == fval(rcount), "R6 data order",
          int'(mem[rs*D + rcount % D]), int'(fval(rcount)));
    end
    @(posedge clk);
    if (wok) wcount++;
    if (rok) rcount++;
    #1;
    wr_req = 1'b0; rd_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(wr_en == '0 && rd_en == '0 && oe == '0, "R1 idle after reset", int'(oe), 0);
    chk(fno[S-1] == 1'b1 && eno[S-1] == 1'b0, "R1 chain flags after reset",
        int'({fno[S-1], eno[S-1]}), 2);

    for (int k = 0; k < N + 1; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int k = 0; k < N; k++) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
    for (int c = 0; c < 60; c++) step(c % 3 != 2, c % 2 == 0);
    for (int c = 0; c < 30; c++) step(c % 5 != 4, c % 4 == 0);
    for (int c = 0; c < 40; c++) step(1'b0, 1'b1);

    @(negedge clk);
    sa_half = 1'b1; #1;
    chk(sa_xow == 1'b1, "R8 half-full routed", int'(sa_xow), 1);
    sa_half = 1'b0; #1;
    chk(sa_xow == 1'b0 && sa_xor == 1'b0, "R8 half-full low", int'({sa_xow, sa_xor}), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      sa_wr = 1'b1; sa_xw = 1'b1; sa_xr = 1'b1; #1;
      chk(sa_wen == 1'b1, "R8 standalone write ignores handoff", int'(sa_wen), 1);
      chk(int'(sa_wa) == k, "R11 standalone write address", int'(sa_wa), k);
    end
    @(negedge clk);
    sa_wr = 1'b0; sa_xw = 1'b0; sa_xr = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      sa_rd = 1'b1; #1;
      chk(sa_ren == 1'b1 && sa_oe == 1'b1, "R3 standalone read", int'(sa_ren), 1);
      chk(int'(sa_ra) == k, "R11 standalone read address", int'(sa_ra), k);
    end
    @(negedge clk);
    sa_fl = 1'b1; sa_wr = 1'b1; sa_rd = 1'b1; #1;
    chk(sa_ren == 1'b0, "R9 read blocked during retransmit", int'(sa_ren), 0);
    chk(sa_wen == 1'b1 && sa_wa == 2'd3, "R9 write unaffected by retransmit", int'(sa_wa), 3);
    @(negedge clk);
    sa_fl = 1'b0; sa_wr = 1'b0; #1;
    chk(sa_ren == 1'b1 && sa_ra == 2'd0, "R9 read address back to zero", int'(sa_ra), 0);
    @(negedge clk);
    sa_rd = 1'b0; sa_wr = 1'b1; sa_full = 1'b1; #1;
    chk(sa_wen == 1'b0 && sa_fno == 1'b0, "R2 full blocks write", int'(sa_wen), 0);
    @(negedge clk);
    sa_wr = 1'b0; sa_full = 1'b0; sa_rd = 1'b1; sa_empty = 1'b1; #1;
    chk(sa_ren == 1'b0 && sa_oe == 1'b0 && sa_eno == 1'b0, "R7 empty blocks read and drive",
        int'({sa_ren, sa_oe}), 0);
    @(negedge clk);
    sa_rd = 1'b0; sa_empty = 1'b0;

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    chk(sa_wa == 2'd0 && sa_ra == 2'd0, "R1 standalone addresses cleared", int'({sa_wa, sa_ra}), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule